// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block works out the program counter value that follows the current instruction and holds the counter register. The caller supplies the flow mode of the current instruction along with the operands it might need: an absolute target, the 16-bit pointer register, the extension bits that widen that pointer, a signed 12-bit relative offset, and a flag that marks a two-word instruction. The unit produces the candidate next address without delay. It loads that address into its program counter register on any clock edge where `advance` is high.

All counter arithmetic is modulo 2^PC_W, where PC_W defaults to 22 bits. The current address that sequential and relative flow start from is the block's own registered counter. Saving return addresses for calls and decoding instructions belong to other blocks.

Top module: `pc_next_unit`

## Requirements
- R1: While `rst_n` is low, `pc_q` is 0, and it stays 0 until the first edge on which `advance` is high.
- R2: Mode code 0 (sequential) gives `pc_next = pc_q + 1` when `two_word` is 0 and `pc_q + 2` when `two_word` is 1, wrapping modulo 2^PC_W.
- R3: Mode code 1 (absolute) gives `pc_next = abs_target`, and `two_word` has no effect.
- R4: Mode code 2 (pointer-indirect) gives `pc_next` equal to `z_ptr` in bits 15:0, with every bit above bit 15 at zero.
- R5: Mode code 3 (widened indirect) gives `pc_next` equal to `ext_hi` in the bits above bit 15 and `z_ptr` in bits 15:0.
- R6: Mode code 4 (relative) gives `pc_next = pc_q + 1 + sign-extended rel_ofs`, wrapping modulo 2^PC_W. This covers offsets from -2048 (0x800) up to +2047 (0x7FF).
- R7: On a rising clock edge with `advance` high, `pc_q` takes the `pc_next` value from before that edge. With `advance` low, `pc_q` keeps its value.
- R8: The unused mode codes 5, 6 and 7 behave exactly like sequential flow (R2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | Load `pc_next` into `pc_q` on this edge |
| mode | input | 3 | Flow mode code of the current instruction |
| abs_target | input | PC_W | Absolute target carried by the instruction |
| z_ptr | input | Z_W | Pointer register contents |
| ext_hi | input | PC_W-Z_W | Extension bits placed above the pointer |
| rel_ofs | input | OFS_W | Signed relative offset in words |
| two_word | input | 1 | Current instruction is two words long |
| pc_next | output | PC_W | Combinational next address |
| pc_q | output | PC_W | Registered program counter |

## Verification
The bench aims at the edges of the relative range. The most negative offset applied at address 0 must wrap to the top of the space, so a unit that fails to sign-extend jumps forward by about 2 K words instead. Sequential flow from the all-ones address must wrap to 0. A unit that extends the adder by one bit, or that mixes up the one-word and two-word steps, lands one word off or outside the range. The bench also checks that plain indirect clears the upper bits while a stale extension value is present, that `two_word` has no effect on jumps, that the spare mode codes fall back to sequential flow, and that the counter holds while `advance` is low.

// File: rtl/pcnu_pkg.sv
package pcnu_pkg;

  typedef enum logic [2:0] {
    FLOW_SEQ  = 3'd0,
    FLOW_ABS  = 3'd1,
    FLOW_PTR  = 3'd2,
    FLOW_WIDE = 3'd3,
    FLOW_REL  = 3'd4
  } flow_e;

  localparam int MODE_W = 3;

endpackage

// File: rtl/pcnu_seq_add.sv
module pcnu_seq_add #(
  parameter int PC_W = 22
) (
  input  logic [PC_W-1:0] pc_cur,
  input  logic            two_word,
  output logic [PC_W-1:0] pc_seq
);

  function automatic logic [PC_W-1:0] step_of(input logic [PC_W-1:0] base,
                                               input logic            dbl);
    logic [PC_W-1:0] inc;
    inc = dbl ? PC_W'(2) : PC_W'(1);
    return base + inc;
  endfunction

  always_comb pc_seq = step_of(pc_cur, two_word);

endmodule

// File: rtl/pcnu_target.sv
module pcnu_target #(
  parameter int PC_W  = 22,
  parameter int Z_W   = 16,
  parameter int OFS_W = 12
) (
  input  logic [PC_W-1:0]      pc_cur,
  input  logic [PC_W-1:0]      abs_target,
  input  logic [Z_W-1:0]       z_ptr,
  input  logic [PC_W-Z_W-1:0]  ext_hi,
  input  logic [OFS_W-1:0]     rel_ofs,
  output logic [PC_W-1:0]      tgt_abs,
  output logic [PC_W-1:0]      tgt_ptr,
  output logic [PC_W-1:0]      tgt_wide,
  output logic [PC_W-1:0]      tgt_rel
);

  localparam int EXT_W = PC_W - Z_W;
  localparam int SX_W  = PC_W - OFS_W;

  function automatic logic [PC_W-1:0] sext_ofs(input logic [OFS_W-1:0] o);
    return {{SX_W{o[OFS_W-1]}}, o};
  endfunction

  function automatic logic [PC_W-1:0] rel_of(input logic [PC_W-1:0]  base,
                                              input logic [OFS_W-1:0] o);
    return base + PC_W'(1) + sext_ofs(o);
  endfunction

  function automatic logic [PC_W-1:0] join_ptr(input logic [EXT_W-1:0] hi,
                                                input logic [Z_W-1:0]   lo);
    return {hi, lo};
  endfunction

  always_comb begin
    tgt_abs  = abs_target;
    tgt_ptr  = join_ptr('0, z_ptr);
    tgt_wide = join_ptr(ext_hi, z_ptr);
    tgt_rel  = rel_of(pc_cur, rel_ofs);
  end

endmodule

// File: rtl/pcnu_sel.sv
module pcnu_sel
  import pcnu_pkg::*;
#(
  parameter int PC_W = 22
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [PC_W-1:0]   pc_seq,
  input  logic [PC_W-1:0]   tgt_abs,
  input  logic [PC_W-1:0]   tgt_ptr,
  input  logic [PC_W-1:0]   tgt_wide,
  input  logic [PC_W-1:0]   tgt_rel,
  output logic              is_seq,
  output logic [PC_W-1:0]   pc_next
);

  always_comb begin
    is_seq  = 1'b0;
    pc_next = pc_seq;
    case (mode)
      FLOW_ABS:  pc_next = tgt_abs;
      FLOW_PTR:  pc_next = tgt_ptr;
      FLOW_WIDE: pc_next = tgt_wide;
      FLOW_REL:  pc_next = tgt_rel;
      default: begin
        is_seq  = 1'b1;
        pc_next = pc_seq;
      end
    endcase
  end

endmodule

// File: rtl/pcnu_pc_reg.sv
module pcnu_pc_reg #(
  parameter int PC_W = 22
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [PC_W-1:0] d,
  output logic [PC_W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

endmodule

// File: rtl/pc_next_unit.sv
module pc_next_unit
  import pcnu_pkg::*;
#(
  parameter int PC_W  = 22,
  parameter int Z_W   = 16,
  parameter int OFS_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 advance,
  input  logic [MODE_W-1:0]    mode,
  input  logic [PC_W-1:0]      abs_target,
  input  logic [Z_W-1:0]       z_ptr,
  input  logic [PC_W-Z_W-1:0]  ext_hi,
  input  logic [OFS_W-1:0]     rel_ofs,
  input  logic                 two_word,
  output logic [PC_W-1:0]      pc_next,
  output logic [PC_W-1:0]      pc_q
);

  logic [PC_W-1:0] pc_seq;
  logic [PC_W-1:0] tgt_abs, tgt_ptr, tgt_wide, tgt_rel;
  logic            is_seq;

  pcnu_seq_add #(.PC_W(PC_W)) u_seq (
    .pc_cur   (pc_q),
    .two_word (two_word),
    .pc_seq   (pc_seq)
  );

  pcnu_target #(.PC_W(PC_W), .Z_W(Z_W), .OFS_W(OFS_W)) u_tgt (
    .pc_cur     (pc_q),
    .abs_target (abs_target),
    .z_ptr      (z_ptr),
    .ext_hi     (ext_hi),
    .rel_ofs    (rel_ofs),
    .tgt_abs    (tgt_abs),
    .tgt_ptr    (tgt_ptr),
    .tgt_wide   (tgt_wide),
    .tgt_rel    (tgt_rel)
  );

  pcnu_sel #(.PC_W(PC_W)) u_sel (
    .mode     (mode),
    .pc_seq   (pc_seq),
    .tgt_abs  (tgt_abs),
    .tgt_ptr  (tgt_ptr),
    .tgt_wide (tgt_wide),
    .tgt_rel  (tgt_rel),
    .is_seq   (is_seq),
    .pc_next  (pc_next)
  );

  pcnu_pc_reg #(.PC_W(PC_W)) u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (advance),
    .d     (pc_next),
    .q     (pc_q)
  );

endmodule

// File: rtl/pcnu_checker.sv
module pcnu_checker #(
  parameter int PC_W = 22,
  parameter int Z_W  = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            advance,
  input logic [2:0]      mode,
  input logic [PC_W-1:0] abs_target,
  input logic [Z_W-1:0]  z_ptr,
  input logic            two_word,
  input logic            is_seq,
  input logic [PC_W-1:0] pc_next,
  input logic [PC_W-1:0] pc_q
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(pc_q));

  p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> pc_q == $past(pc_next));

  p_abs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd1 |-> pc_next == abs_target);

  p_ptr_zero_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode == 3'd2 |-> (pc_next[PC_W-1:Z_W] == '0) && (pc_next[Z_W-1:0] == z_ptr));

  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'd0 && !two_word) |-> pc_next == pc_q + PC_W'(1));

  p_spare_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode >= 3'd5) |-> is_seq);

endmodule

bind pc_next_unit pcnu_checker #(.PC_W(PC_W), .Z_W(Z_W)) u_pcnu_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .advance    (advance),
  .mode       (mode),
  .abs_target (abs_target),
  .z_ptr      (z_ptr),
  .two_word   (two_word),
  .is_seq     (is_seq),
  .pc_next    (pc_next),
  .pc_q       (pc_q)
);

// File: tb/pc_next_unit_bench.sv
module pc_next_unit_bench;

  localparam int PC_W = 22;
  localparam int Z_W  = 16;
  localparam int OW   = 12;
  localparam int EW   = PC_W - Z_W;

  typedef struct packed {
    logic [2:0]      m;
    logic [PC_W-1:0] a;
    logic [Z_W-1:0]  z;
    logic [EW-1:0]   e;
    logic [OW-1:0]   o;
    logic            tw;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{m:3'd0, a:22'h0,      z:16'h0,    e:6'h0,  o:12'h0,   tw:1'b0}, // R2 +1
    '{m:3'd0, a:22'h0,      z:16'h0,    e:6'h0,  o:12'h0,   tw:1'b1}, // R2 +2
    '{m:3'd1, a:22'h12345,  z:16'h1,    e:6'h3,  o:12'h5,   tw:1'b1}, // R3
    '{m:3'd2, a:22'h3,      z:16'hBEEF, e:6'h3F, o:12'h0,   tw:1'b0}, // R4
    '{m:3'd3, a:22'h0,      z:16'h1234, e:6'h2A, o:12'h0,   tw:1'b0}, // R5
    '{m:3'd4, a:22'h0,      z:16'h0,    e:6'h0,  o:12'h7FF, tw:1'b0}, // R6 max
    '{m:3'd4, a:22'h0,      z:16'h0,    e:6'h0,  o:12'h800, tw:1'b1}, // R6 min
    '{m:3'd5, a:22'h777,    z:16'h0,    e:6'h0,  o:12'h0,   tw:1'b1}, // R8
    '{m:3'd1, a:22'h3FFFFF, z:16'h0,    e:6'h0,  o:12'h0,   tw:1'b0}, // R3
    '{m:3'd0, a:22'h0,      z:16'h0,    e:6'h0,  o:12'h0,   tw:1'b0}, // R2 wrap
    '{m:3'd4, a:22'h0,      z:16'h0,    e:6'h0,  o:12'h800, tw:1'b0}, // R6 wrap
    '{m:3'd7, a:22'h0,      z:16'h0,    e:6'h0,  o:12'h0,   tw:1'b0}  // R8
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            advance = 1'b0;
  logic [2:0]      mode = '0;
  logic [PC_W-1:0] abs_target = '0;
  logic [Z_W-1:0]  z_ptr = '0;
  logic [EW-1:0]   ext_hi = '0;
  logic [OW-1:0]   rel_ofs = '0;
  logic            two_word = 1'b0;
  logic [PC_W-1:0] pc_next, pc_q;

  int total = 0;
  int bad   = 0;
  logic [PC_W-1:0] shadow = '0;

  always #4 clk = ~clk;

  pc_next_unit u_pc_next_unit (
    .clk(clk), .rst_n(rst_n), .advance(advance), .mode(mode),
    .abs_target(abs_target), .z_ptr(z_ptr), .ext_hi(ext_hi),
    .rel_ofs(rel_ofs), .two_word(two_word), .pc_next(pc_next), .pc_q(pc_q)
  );

  function automatic logic [PC_W-1:0] model(input logic [PC_W-1:0] pc, input vec_t v);
    int signed off;
    case (v.m)
      3'd1: return v.a;
      3'd2: return PC_W'(v.z);
      3'd3: return PC_W'(v.e) << Z_W;
      3'd4: begin
        off = int'(v.o);
        if (off >= 2048) off = off - 4096;
        return PC_W'(int'(pc) + 1 + off);
      end
      default: return pc + (v.tw ? PC_W'(2) : PC_W'(1));
    endcase
  endfunction

  task automatic check(input string req, input logic [PC_W-1:0] act,
                       input logic [PC_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    mode = v.m; abs_target = v.a; z_ptr = v.z; ext_hi = v.e;
    rel_ofs = v.o; two_word = v.tw;
  endtask

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] e;
    vec_t v;
    repeat (3) @(negedge clk);
    check("R1 reset", pc_q, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", pc_q, '0);

    for (int i = 0; i < NV; i++) begin
      v = VECS[i];
      apply(v);
      e = model(shadow, v);
      if (v.m == 3'd3) e = e | PC_W'(v.z);
      #1;
      check(req_of(v.m), pc_next, e);
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
      shadow = e;
      check("R7 load", pc_q, shadow);
    end

    // R7: hold with advance low while a jump is presented
    v = '{m:3'd1, a:22'h2AAAA, z:16'h0, e:6'h0, o:12'h0, tw:1'b0};
    apply(v);
    repeat (2) @(negedge clk);
    check("R7 hold", pc_q, shadow);

    // R3: two_word ignored for absolute
    v.tw = 1'b1;
    apply(v);
    #1;
    check("R3 two_word ignored", pc_next, 22'h2AAAA);

    // R4: stale ext bits must not leak into plain indirect
    v = '{m:3'd2, a:22'h0, z:16'hFFFF, e:6'h3F, o:12'h0, tw:1'b1};
    apply(v);
    #1;
    check("R4 upper zero", pc_next, 22'h00FFFF);

    // R1: reset mid-run
    advance = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", pc_q, '0);
    @(negedge clk);
    advance = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stays zero", pc_q, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule